// File: doc/BRIEF.md
# Nested Read/Write Signature Conflict Checker

This block tracks, for each hardware thread, the set of physical block addresses read and written inside a transaction. Each set is a hashed bit vector. A membership test can report an address that was never inserted, but it never misses one that was. Transactional loads and stores from the local core are inserted into the signatures of the issuing thread. Coherence requests arriving from other cores are tested against every thread's signatures, and a hit is reported as a conflict per thread. The surrounding protocol logic turns that report into a negative acknowledgement.

Nesting is handled with a small per-thread snapshot stack. A nested begin pushes the current pair of signatures. Inner aborts and open commits pop the snapshot back. Closed commits keep the merged sets. The outermost commit or abort empties everything.

A separate summary pair of signatures stands for threads that have been switched out while inside a transaction. The operating system merges a thread's signatures into the summary when it suspends that thread. Every local access is checked against the summary, and a hit raises a trap. A per-thread flag records whether the thread has made an older requester wait. When the thread itself is refused by another core, the block uses that flag to decide between waiting and aborting.

Top module: `sig_conflict_top`

## Requirements
- R1: After reset every signature and the summary are empty, every nesting level is 0, no request conflicts and no access traps.
- R2: Both hashes split the zero-padded block address into 6-bit chunks c_k, counted from bit 0. Hash A is the XOR of all c_k. Hash B is the XOR of each c_k rotated left by (k+1) mod 6. An access while the thread's level is above 0 sets bits A and B of its read signature for a load (acc_store=0) or of its write signature for a store. An access at level 0 changes nothing.
- R3: An address hits a signature when both of its hash bits are set. A request with rq_excl=1 conflicts with a thread on a hit in its read or write signature. A request with rq_excl=0 conflicts only on a hit in the write signature.
- R4: tx_op 0 (begin) raises the thread's level by one. At level 0 it also records tx_ts as the thread's timestamp. At level 1 or above it pushes the current signatures.
- R5: tx_op 3 (abort) above level 1 restores the signatures pushed by the matching begin and lowers the level by one.
- R6: tx_op 1 (closed commit) above level 1 lowers the level by one and keeps the signatures, so the inner sets stay in the outer one.
- R7: tx_op 2 (open commit) above level 1 restores the signatures pushed by the matching begin and lowers the level by one.
- R8: Any commit or abort at level 1 empties both signatures, clears the wait flag and returns the level to 0.
- R9: A begin at level 5, which is the stack depth of 4 plus one, raises tx_err in that cycle and changes nothing. So does a commit or abort at level 0.
- R10: sched_out_valid ORs the selected thread's signatures into the summary pair, and sum_clear empties the summary. An access traps when a load hits the summary write signature, or when a store hits either summary signature.
- R11: A conflicting incoming request whose rq_ts is lower than the thread's timestamp sets that thread's flag. When nack_valid names the thread, nack_abort is 1 if the flag is set; otherwise nack_wait is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Local memory access this cycle |
| acc_tid | input | 1 | Thread issuing the access |
| acc_store | input | 1 | 1 for store, 0 for load |
| acc_addr | input | 26 | Physical block address of the access |
| sum_trap | output | 1 | Access hits the summary signatures |
| tx_valid | input | 1 | Transaction control operation this cycle |
| tx_tid | input | 1 | Thread addressed by the operation; also selects nest_level |
| tx_op | input | 2 | 0 begin, 1 closed commit, 2 open commit, 3 abort |
| tx_ts | input | 8 | Timestamp taken at an outermost begin |
| tx_err | output | 1 | Operation rejected (stack full or no transaction) |
| nest_level | output | 3 | Nesting level of thread tx_tid |
| rq_valid | input | 1 | Incoming coherence request |
| rq_excl | input | 1 | 1 exclusive, 0 shared |
| rq_addr | input | 26 | Block address of the request |
| rq_ts | input | 8 | Requester timestamp |
| rq_conflict | output | 2 | Per-thread conflict for the request |
| nack_valid | input | 1 | Local thread was refused by another core |
| nack_tid | input | 1 | Refused thread |
| nack_wait | output | 1 | Refused thread should retry later |
| nack_abort | output | 1 | Refused thread must abort |
| sched_out_valid | input | 1 | Merge a suspended thread into the summary |
| sched_out_tid | input | 1 | Thread being suspended |
| sum_clear | input | 1 | Empty the summary signatures |

## Verification
A wrong bit in a signature appears on rq_conflict or sum_trap at the first query for an address whose hash covers that bit. A dropped bit is a missed conflict, which is the error that matters. A stray bit shows up only when a query happens to hash onto it, so the bench predicts every expected hit from its own hash model. A wrong nesting level, or a bad stack slot, shows on nest_level in the cycle after the operation. It can also show later as signatures that fail to come back at the matching abort. A stale wait flag shows only at the next refusal, as abort instead of wait.

// File: rtl/sig_conflict_pkg.sv
`timescale 1ns/1ps
package sig_conflict_pkg;
   typedef enum logic [1:0] {
      TXO_BEGIN  = 2'd0,
      TXO_CLOSED = 2'd1,
      TXO_OPEN   = 2'd2,
      TXO_ABORT  = 2'd3
   } txop_e;
endpackage

// File: rtl/sig_hash.sv
`timescale 1ns/1ps
module sig_hash #(
   parameter int ADDR_W   = 26,
   parameter int SIG_W    = 64,
   parameter bit TWO_HASH = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [SIG_W-1:0]  mask
);
   localparam int IDX_W = $clog2(SIG_W);
   localparam int NCH   = (ADDR_W + IDX_W - 1) / IDX_W;
   localparam int PAD_W = NCH * IDX_W;

   logic [PAD_W-1:0] pad;
   logic [IDX_W-1:0] idx_a, idx_b;

   assign pad = PAD_W'(addr);

   // fold the chunks: plain XOR for A, rotated XOR for B
   always_comb begin
      idx_a = '0;
      idx_b = '0;
      for (int k = 0; k < NCH; k++) begin
         for (int b = 0; b < IDX_W; b++) begin
            idx_a[b]                       ^= pad[k*IDX_W + b];
            idx_b[(b + k + 1) % IDX_W]     ^= pad[k*IDX_W + b];
         end
      end
   end

   generate
      if (TWO_HASH) begin : g_two
         assign mask = (SIG_W'(1) << idx_a) | (SIG_W'(1) << idx_b);
      end else begin : g_one
         logic unused_b;
         assign unused_b = ^idx_b;
         assign mask = SIG_W'(1) << idx_a;
      end
   endgenerate
endmodule

// File: rtl/sig_thread.sv
`timescale 1ns/1ps
module sig_thread
   import sig_conflict_pkg::*;
#(
   parameter int SIG_W   = 64,
   parameter int STACK_D = 4,
   parameter int TS_W    = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          acc_en,
   input  logic                          acc_store,
   input  logic [SIG_W-1:0]              acc_mask,
   input  logic                          tx_en,
   input  logic [1:0]                    tx_op,
   input  logic [TS_W-1:0]               tx_ts,
   input  logic                          rq_valid,
   input  logic                          rq_excl,
   input  logic [SIG_W-1:0]              rq_mask,
   input  logic [TS_W-1:0]               rq_ts,
   output logic [SIG_W-1:0]              rd_sig,
   output logic [SIG_W-1:0]              wr_sig,
   output logic [$clog2(STACK_D+2)-1:0]  depth,
   output logic                          tx_err,
   output logic                          rq_hit,
   output logic                          stall_older
);
   localparam int DW = $clog2(STACK_D + 2);

   logic [SIG_W-1:0] stk_rd [STACK_D];
   logic [SIG_W-1:0] stk_wr [STACK_D];
   logic [SIG_W-1:0] pop_rd, pop_wr;
   logic [TS_W-1:0]  my_ts;
   logic [DW-1:0]    dm1, dm2;
   logic             full, idle, outer, tx_ok, ending, is_begin;

   assign dm1      = depth - DW'(1);
   assign dm2      = depth - DW'(2);
   assign full     = (depth == DW'(STACK_D + 1));
   assign idle     = (depth == '0);
   assign outer    = (depth == DW'(1));
   assign is_begin = (txop_e'(tx_op) == TXO_BEGIN);
   assign tx_err   = tx_en & ((is_begin & full) | (!is_begin & idle));
   assign tx_ok    = tx_en & ~tx_err;
   assign ending   = tx_ok & !is_begin & outer;

   assign rq_hit = rq_valid &
                   (((wr_sig & rq_mask) == rq_mask) |
                    (rq_excl & ((rd_sig & rq_mask) == rq_mask)));

   always_comb begin
      pop_rd = '0;
      pop_wr = '0;
      for (int i = 0; i < STACK_D; i++) begin
         if (dm2 == DW'(i)) begin
            pop_rd = stk_rd[i];
            pop_wr = stk_wr[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_sig      <= '0;
         wr_sig      <= '0;
         depth       <= '0;
         my_ts       <= '0;
         stall_older <= 1'b0;
         for (int i = 0; i < STACK_D; i++) begin
            stk_rd[i] <= '0;
            stk_wr[i] <= '0;
         end
      end else begin
         if (tx_ok) begin
            case (txop_e'(tx_op))
               TXO_BEGIN: begin
                  if (idle) my_ts <= tx_ts;
                  for (int i = 0; i < STACK_D; i++) begin
                     if (!idle && dm1 == DW'(i)) begin
                        stk_rd[i] <= rd_sig;
                        stk_wr[i] <= wr_sig;
                     end
                  end
                  depth <= depth + DW'(1);
               end
               TXO_CLOSED: begin
                  if (outer) begin
                     rd_sig <= '0;
                     wr_sig <= '0;
                  end
                  depth <= dm1;
               end
               default: begin
                  if (outer) begin
                     rd_sig <= '0;
                     wr_sig <= '0;
                  end else begin
                     rd_sig <= pop_rd;
                     wr_sig <= pop_wr;
                  end
                  depth <= dm1;
               end
            endcase
         end else if (acc_en && !idle) begin
            if (acc_store) wr_sig <= wr_sig | acc_mask;
            else           rd_sig <= rd_sig | acc_mask;
         end

         if (ending)                         stall_older <= 1'b0;
         else if (rq_hit && (rq_ts < my_ts)) stall_older <= 1'b1;
      end
   end
endmodule

// File: rtl/sig_conflict_top.sv
`timescale 1ns/1ps
module sig_conflict_top #(
   parameter int NUM_THREADS = 2,
   parameter int ADDR_W      = 26,
   parameter int SIG_W       = 64,
   parameter int STACK_D     = 4,
   parameter int TS_W        = 8,
   parameter bit TWO_HASH    = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           acc_valid,
   input  logic [$clog2(NUM_THREADS)-1:0] acc_tid,
   input  logic                           acc_store,
   input  logic [ADDR_W-1:0]              acc_addr,
   output logic                           sum_trap,
   input  logic                           tx_valid,
   input  logic [$clog2(NUM_THREADS)-1:0] tx_tid,
   input  logic [1:0]                     tx_op,
   input  logic [TS_W-1:0]                tx_ts,
   output logic                           tx_err,
   output logic [$clog2(STACK_D+2)-1:0]   nest_level,
   input  logic                           rq_valid,
   input  logic                           rq_excl,
   input  logic [ADDR_W-1:0]              rq_addr,
   input  logic [TS_W-1:0]                rq_ts,
   output logic [NUM_THREADS-1:0]         rq_conflict,
   input  logic                           nack_valid,
   input  logic [$clog2(NUM_THREADS)-1:0] nack_tid,
   output logic                           nack_wait,
   output logic                           nack_abort,
   input  logic                           sched_out_valid,
   input  logic [$clog2(NUM_THREADS)-1:0] sched_out_tid,
   input  logic                           sum_clear
);
   localparam int TID_W = $clog2(NUM_THREADS);
   localparam int DW    = $clog2(STACK_D + 2);

   generate
      if (NUM_THREADS < 2)
         begin : g_bad_threads $error("NUM_THREADS must be at least 2"); end
      if (SIG_W < 8 || (SIG_W & (SIG_W - 1)) != 0)
         begin : g_bad_sig $error("SIG_W must be a power of two, 8 or more"); end
      if (STACK_D < 1)
         begin : g_bad_stack $error("STACK_D must be at least 1"); end
      if (ADDR_W < $clog2(SIG_W))
         begin : g_bad_addr $error("ADDR_W narrower than one hash chunk"); end
   endgenerate

   logic [SIG_W-1:0]                   acc_mask, rq_mask;
   logic [NUM_THREADS-1:0][SIG_W-1:0]  th_rd, th_wr;
   logic [NUM_THREADS-1:0][DW-1:0]     th_depth;
   logic [NUM_THREADS-1:0]             th_err, th_stall;
   logic [SIG_W-1:0]                   sum_rd, sum_wr;
   logic [SIG_W-1:0]                   out_rd, out_wr;

   sig_hash #(.ADDR_W(ADDR_W), .SIG_W(SIG_W), .TWO_HASH(TWO_HASH)) u_hash_acc (
      .addr(acc_addr), .mask(acc_mask));
   sig_hash #(.ADDR_W(ADDR_W), .SIG_W(SIG_W), .TWO_HASH(TWO_HASH)) u_hash_rq (
      .addr(rq_addr), .mask(rq_mask));

   generate
      for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
         sig_thread #(.SIG_W(SIG_W), .STACK_D(STACK_D), .TS_W(TS_W)) u_thr (
            .clk        (clk),
            .rst_n      (rst_n),
            .acc_en     (acc_valid && acc_tid == TID_W'(t)),
            .acc_store  (acc_store),
            .acc_mask   (acc_mask),
            .tx_en      (tx_valid && tx_tid == TID_W'(t)),
            .tx_op      (tx_op),
            .tx_ts      (tx_ts),
            .rq_valid   (rq_valid),
            .rq_excl    (rq_excl),
            .rq_mask    (rq_mask),
            .rq_ts      (rq_ts),
            .rd_sig     (th_rd[t]),
            .wr_sig     (th_wr[t]),
            .depth      (th_depth[t]),
            .tx_err     (th_err[t]),
            .rq_hit     (rq_conflict[t]),
            .stall_older(th_stall[t])
         );
      end
   endgenerate

   assign tx_err = |th_err;

   always_comb begin
      nest_level = '0;
      nack_abort = 1'b0;
      out_rd     = '0;
      out_wr     = '0;
      for (int t = 0; t < NUM_THREADS; t++) begin
         if (tx_tid == TID_W'(t))        nest_level = th_depth[t];
         if (nack_tid == TID_W'(t))      nack_abort = nack_valid & th_stall[t];
         if (sched_out_tid == TID_W'(t)) begin
            out_rd = th_rd[t];
            out_wr = th_wr[t];
         end
      end
   end
   assign nack_wait = nack_valid & ~nack_abort;

   always_ff @(posedge clk) begin
      if (!rst_n || sum_clear) begin
         sum_rd <= '0;
         sum_wr <= '0;
      end else if (sched_out_valid) begin
         sum_rd <= sum_rd | out_rd;
         sum_wr <= sum_wr | out_wr;
      end
   end

   assign sum_trap = acc_valid &
                     (((sum_wr & acc_mask) == acc_mask) |
                      (acc_store & ((sum_rd & acc_mask) == acc_mask)));
endmodule

// File: rtl/sig_conflict_chk.sv
`timescale 1ns/1ps
module sig_conflict_chk #(
   parameter int NUM_THREADS = 2,
   parameter int SIG_W       = 64,
   parameter int STACK_D     = 4
) (
   input logic                                    clk,
   input logic                                    rst_n,
   input logic                                    acc_valid,
   input logic                                    sum_trap,
   input logic                                    tx_valid,
   input logic [$clog2(NUM_THREADS)-1:0]          tx_tid,
   input logic [1:0]                              tx_op,
   input logic                                    tx_err,
   input logic                                    nack_valid,
   input logic                                    nack_wait,
   input logic                                    nack_abort,
   input logic [NUM_THREADS-1:0][SIG_W-1:0]       th_rd,
   input logic [NUM_THREADS-1:0][SIG_W-1:0]       th_wr,
   input logic [NUM_THREADS-1:0][$clog2(STACK_D+2)-1:0] th_depth
);
   localparam int DW    = $clog2(STACK_D + 2);
   localparam int TID_W = $clog2(NUM_THREADS);

   p_trap_needs_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sum_trap |-> acc_valid);

   p_nack_one_answer_r11: assert property (@(posedge clk) disable iff (!rst_n)
      nack_valid |-> ($countones({nack_wait, nack_abort}) == 1));

   p_quiet_without_nack_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !nack_valid |-> !(nack_wait || nack_abort));

   generate
      for (genvar t = 0; t < NUM_THREADS; t++) begin : g_t
         p_depth_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
            th_depth[t] <= DW'(STACK_D + 1));

         p_overflow_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_valid && tx_tid == TID_W'(t) && tx_op == 2'd0 &&
             th_depth[t] == DW'(STACK_D + 1)) |-> tx_err);

         p_idle_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (th_depth[t] == '0) |-> (th_rd[t] == '0 && th_wr[t] == '0));

         p_begin_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_valid && tx_tid == TID_W'(t) && tx_op == 2'd0 && !tx_err)
            |=> (th_depth[t] == DW'($past(th_depth[t]) + DW'(1))));

         p_closed_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_valid && tx_tid == TID_W'(t) && tx_op == 2'd1 && th_depth[t] > DW'(1))
            |=> ($stable(th_rd[t]) && $stable(th_wr[t])));

         p_grow_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !(tx_valid && tx_tid == TID_W'(t))
            |=> (((th_rd[t] & $past(th_rd[t])) == $past(th_rd[t])) &&
                 ((th_wr[t] & $past(th_wr[t])) == $past(th_wr[t]))));
      end
   endgenerate
endmodule

bind sig_conflict_top sig_conflict_chk #(
   .NUM_THREADS(NUM_THREADS), .SIG_W(SIG_W), .STACK_D(STACK_D)
) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .sum_trap(sum_trap),
   .tx_valid(tx_valid), .tx_tid(tx_tid), .tx_op(tx_op), .tx_err(tx_err),
   .nack_valid(nack_valid), .nack_wait(nack_wait), .nack_abort(nack_abort),
   .th_rd(th_rd), .th_wr(th_wr), .th_depth(th_depth)
);

// File: tb/sim_sig_conflict_top.sv
`timescale 1ns/1ps
module sim_sig_conflict_top;
   localparam int AW = 26;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n, acc_valid, acc_store, sum_trap, tx_valid, tx_err;
   logic acc_tid, tx_tid, nack_tid, sched_out_tid;
   logic [AW-1:0] acc_addr, rq_addr;
   logic [1:0] tx_op, rq_conflict;
   logic [7:0] tx_ts, rq_ts;
   logic [2:0] nest_level;
   logic rq_valid, rq_excl, nack_valid, nack_wait, nack_abort, sched_out_valid, sum_clear;

   int errs = 0, checks = 0;

   sig_conflict_top u0 (.*);

   // {addr[25:0], store, expect exclusive hit, expect shared hit}
   localparam logic [28:0] TBL [12] = '{
      {26'h0000001, 1'b0, 1'b1, 1'b0}, {26'h0000040, 1'b1, 1'b1, 1'b1},
      {26'h3FFFFFF, 1'b0, 1'b1, 1'b0}, {26'h1234567, 1'b1, 1'b1, 1'b1},
      {26'h2AAAAAA, 1'b0, 1'b1, 1'b0}, {26'h1555555, 1'b1, 1'b1, 1'b1},
      {26'h0F0F0F0, 1'b0, 1'b1, 1'b0}, {26'h00000C0, 1'b1, 1'b1, 1'b1},
      {26'h2000000, 1'b0, 1'b1, 1'b0}, {26'h0ABCDEF, 1'b1, 1'b1, 1'b1},
      {26'h3000003, 1'b0, 1'b1, 1'b0}, {26'h0000000, 1'b1, 1'b1, 1'b1}
   };

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] ref_mask(logic [AW-1:0] a);
      logic [29:0] p;
      logic [5:0] ha, hb;
      p = {4'b0, a};
      ha = '0; hb = '0;
      for (int j = 0; j < 6; j++)
         for (int k = 0; k < 5; k++) begin
            ha[j] = ha[j] ^ p[k*6 + j];
            hb[j] = hb[j] ^ p[k*6 + ((j - k - 1 + 12) % 6)];
         end
      return (64'd1 << ha) | (64'd1 << hb);
   endfunction

   function automatic logic covered(logic [AW-1:0] a, logic [63:0] set);
      return ((ref_mask(a) & set) == ref_mask(a));
   endfunction

   task automatic do_tx(logic tid, logic [1:0] op, logic [7:0] ts, output logic err);
      @(negedge clk);
      tx_valid = 1'b1; tx_tid = tid; tx_op = op; tx_ts = ts;
      #1 err = tx_err;
      @(posedge clk); #1 tx_valid = 1'b0;
   endtask

   task automatic do_acc(logic tid, logic st, logic [AW-1:0] a, output logic trap);
      @(negedge clk);
      acc_valid = 1'b1; acc_tid = tid; acc_store = st; acc_addr = a;
      #1 trap = sum_trap;
      @(posedge clk); #1 acc_valid = 1'b0;
   endtask

   task automatic do_rq(logic ex, logic [AW-1:0] a, logic [7:0] ts, output logic [1:0] c);
      @(negedge clk);
      rq_valid = 1'b1; rq_excl = ex; rq_addr = a; rq_ts = ts;
      #1 c = rq_conflict;
      @(posedge clk); #1 rq_valid = 1'b0;
   endtask

   task automatic get_level(logic tid, output logic [2:0] lv);
      @(negedge clk);
      tx_tid = tid;
      #1 lv = nest_level;
   endtask

   task automatic do_nack(logic tid, output logic w, output logic ab);
      @(negedge clk);
      nack_valid = 1'b1; nack_tid = tid;
      #1 begin w = nack_wait; ab = nack_abort; end
      @(posedge clk); #1 nack_valid = 1'b0;
   endtask

   initial begin
      #(8 * 100000);
      errs++;
      $display("FAIL watchdog: got hung expected done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      logic e, tr, w, ab;
      logic [1:0] c;
      logic [2:0] lv;
      logic [AW-1:0] xa, ya, za;
      rst_n = 1'b0; acc_valid = 0; acc_tid = 0; acc_store = 0; acc_addr = '0;
      tx_valid = 0; tx_tid = 0; tx_op = 0; tx_ts = 0;
      rq_valid = 0; rq_excl = 0; rq_addr = '0; rq_ts = 8'hFF;
      nack_valid = 0; nack_tid = 0; sched_out_valid = 0; sched_out_tid = 0; sum_clear = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      get_level(1'b0, lv); check("R1 level t0", lv, 0);
      get_level(1'b1, lv); check("R1 level t1", lv, 0);
      do_rq(1'b1, 26'h0, 8'hFF, c); check("R1 no conflict", c, 0);
      do_acc(1'b0, 1'b1, 26'h0, tr); check("R1 no trap", tr, 0);

      // R2 access outside a transaction is ignored
      do_acc(1'b0, 1'b1, 26'h1234567, tr);
      do_rq(1'b1, 26'h1234567, 8'hFF, c); check("R2 idle access ignored", c, 0);

      // R2/R3 table walk on thread 0
      for (int i = 0; i < 12; i++) begin
         logic [28:0] row;
         row = TBL[i];
         do_tx(1'b0, 2'd0, 8'd9, e);
         do_acc(1'b0, row[2], row[28:3], tr);
         do_rq(1'b1, row[28:3], 8'hFF, c);
         check("R3 exclusive hit t0", c[0], row[1]);
         check("R3 other thread clean", c[1], 0);
         do_rq(1'b0, row[28:3], 8'hFF, c);
         check("R3 shared hit t0", c[0], row[0]);
         do_tx(1'b0, 2'd3, 8'd0, e);
      end

      // R2 hash model: membership of other addresses
      xa = 26'h0123456;
      do_tx(1'b1, 2'd0, 8'd9, e);
      do_acc(1'b1, 1'b1, xa, tr);
      for (int i = 0; i < 4; i++) begin
         logic [AW-1:0] qa;
         qa = (i == 0) ? xa : (i == 1) ? (xa ^ 26'h1) : (i == 2) ? 26'h2ABCDEF : 26'h0000041;
         do_rq(1'b0, qa, 8'hFF, c);
         check("R2 hash membership t1", c[1], covered(qa, ref_mask(xa)));
      end
      do_tx(1'b1, 2'd1, 8'd0, e);
      do_rq(1'b1, xa, 8'hFF, c); check("R8 closed outermost clears", c[1], 0);

      // R4..R8 nesting
      xa = 26'h0000100; ya = 26'h0002000; za = 26'h0300000;
      do_tx(1'b0, 2'd0, 8'd10, e);
      do_acc(1'b0, 1'b1, xa, tr);
      do_tx(1'b0, 2'd0, 8'd0, e);
      get_level(1'b0, lv); check("R4 nested level", lv, 2);
      do_acc(1'b0, 1'b1, ya, tr);
      do_rq(1'b0, ya, 8'hFF, c); check("R4 inner insert", c[0], 1);
      do_tx(1'b0, 2'd3, 8'd0, e);
      get_level(1'b0, lv); check("R5 abort level", lv, 1);
      do_rq(1'b0, ya, 8'hFF, c); check("R5 inner set dropped", c[0], covered(ya, ref_mask(xa)));
      do_rq(1'b0, xa, 8'hFF, c); check("R5 outer set kept", c[0], 1);
      do_tx(1'b0, 2'd0, 8'd0, e);
      do_acc(1'b0, 1'b1, ya, tr);
      do_tx(1'b0, 2'd1, 8'd0, e);
      get_level(1'b0, lv); check("R6 closed level", lv, 1);
      do_rq(1'b0, ya, 8'hFF, c); check("R6 child merged", c[0], 1);
      do_tx(1'b0, 2'd0, 8'd0, e);
      do_acc(1'b0, 1'b0, za, tr);
      do_rq(1'b1, za, 8'hFF, c); check("R7 child read present", c[0], 1);
      do_tx(1'b0, 2'd2, 8'd0, e);
      get_level(1'b0, lv); check("R7 open level", lv, 1);
      do_rq(1'b1, za, 8'hFF, c);
      check("R7 child read dropped", c[0], covered(za, ref_mask(xa) | ref_mask(ya)));
      do_rq(1'b0, ya, 8'hFF, c); check("R7 parent kept", c[0], 1);
      do_tx(1'b0, 2'd3, 8'd0, e);
      get_level(1'b0, lv); check("R8 outermost level", lv, 0);
      do_rq(1'b1, xa, 8'hFF, c); check("R8 outermost clears", c[0], 0);

      // R9 stack overflow and underflow
      for (int i = 0; i < 5; i++) begin
         do_tx(1'b0, 2'd0, 8'd3, e);
         check("R9 legal begin", e, 0);
      end
      get_level(1'b0, lv); check("R9 full level", lv, 5);
      do_tx(1'b0, 2'd0, 8'd3, e); check("R9 overflow error", e, 1);
      get_level(1'b0, lv); check("R9 level unchanged", lv, 5);
      for (int i = 0; i < 5; i++) do_tx(1'b0, 2'd3, 8'd0, e);
      get_level(1'b0, lv); check("R9 unwound", lv, 0);
      do_tx(1'b0, 2'd1, 8'd0, e); check("R9 commit at level 0", e, 1);
      do_tx(1'b0, 2'd3, 8'd0, e); check("R9 abort at level 0", e, 1);

      // R10 summary signatures
      xa = 26'h0000005; ya = 26'h0040000;
      do_tx(1'b1, 2'd0, 8'd7, e);
      do_acc(1'b1, 1'b0, xa, tr);
      do_acc(1'b1, 1'b1, ya, tr);
      @(negedge clk); sched_out_valid = 1'b1; sched_out_tid = 1'b1;
      @(posedge clk); #1 sched_out_valid = 1'b0;
      do_tx(1'b1, 2'd3, 8'd0, e);
      do_acc(1'b0, 1'b0, xa, tr); check("R10 load vs summary read", tr, covered(xa, ref_mask(ya)));
      do_acc(1'b0, 1'b0, ya, tr); check("R10 load vs summary write", tr, 1);
      do_acc(1'b0, 1'b1, xa, tr); check("R10 store vs summary read", tr, 1);
      @(negedge clk); sum_clear = 1'b1;
      @(posedge clk); #1 sum_clear = 1'b0;
      do_acc(1'b0, 1'b1, ya, tr); check("R10 cleared summary", tr, 0);

      // R11 wait or abort
      xa = 26'h0000880; ya = 26'h3300000;
      do_tx(1'b0, 2'd0, 8'd50, e);
      do_acc(1'b0, 1'b1, xa, tr);
      do_rq(1'b0, xa, 8'd80, c); check("R11 younger conflict", c[0], 1);
      do_nack(1'b0, w, ab); check("R11 wait after younger", {w, ab}, 2'b10);
      do_rq(1'b0, ya, 8'd20, c); check("R11 older no hit", c[0], covered(ya, ref_mask(xa)));
      do_nack(1'b0, w, ab);
      check("R11 no flag without hit", ab, covered(ya, ref_mask(xa)));
      do_rq(1'b1, xa, 8'd20, c); check("R11 older conflict", c[0], 1);
      do_nack(1'b0, w, ab); check("R11 abort after older", {w, ab}, 2'b01);
      do_tx(1'b0, 2'd3, 8'd0, e);
      do_tx(1'b0, 2'd0, 8'd50, e);
      do_nack(1'b0, w, ab); check("R8 flag cleared at end", {w, ab}, 2'b10);
      do_tx(1'b0, 2'd1, 8'd0, e);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule